// File: doc/BRIEF.md
# Edge-Selectable Wakeup Input Port

This block is a four-pin input port. Each pin can also bring the controller out of its idle state. Every pin goes through a two-flop synchronizer. The synchronized value is always readable by the core, whatever the pin's wakeup setting. The settings are chosen per pin:

- wake on a falling edge,
- wake on a rising edge,
- no wakeup, in which case the pin is an ordinary input.

The pad pull resistor is chosen from the same settings. A falling-edge pin pulls up, and a rising-edge pin pulls down.

The sleep controller receives a single-cycle wakeup pulse. A pulse is produced only while the core reports that it is idle, and only for an edge that matches an enabled pin's setting. Edges on several pins in the same cycle give one pulse.

Changing a pin's wakeup configuration never creates a pulse on its own:

- In any cycle where the edge configuration differs from the previous cycle, the detector is re-seeded from the current synchronized value and all edges are discarded.
- After reset, edges are ignored until the synchronizer and detector hold real pin samples.

Top module: `wkp_port`

## Requirements
- R1: `port_o[i]` equals `pin_i[i]` as sampled on the rising clock edge two cycles earlier (two synchronizer flops). While reset is held, `port_o` is 0.
- R2: A pin with `wake_en_i[i]=1` and `edge_rise_i[i]=0` produces exactly one wakeup pulse when its synchronized value goes from 1 to 0. This applies while `idle_i` is 1 and the configuration is stable. `wake_o` goes high in the third clock cycle after the pin changes.
- R3: A pin with `wake_en_i[i]=1` and `edge_rise_i[i]=1` produces exactly one wakeup pulse when its synchronized value goes from 0 to 1, under the same conditions as R2. A 1-to-0 change on that pin gives no pulse.
- R4: A pin with `wake_en_i[i]=0` never causes a pulse, on either edge, and stays readable on `port_o`.
- R5: An edge whose detection cycle sees `idle_i` at 0 is discarded. No pulse appears then or later, even if `idle_i` rises afterwards.
- R6: `wake_o` is never high in two consecutive cycles. Edges on several enabled pins detected in the same cycle produce one pulse.
- R7: In any cycle where `{edge_rise_i, wake_en_i}` differs from its value in the previous cycle, the detector is re-seeded and the edges seen in that cycle are discarded. `wake_o` is 0 in the following cycle.
- R8: For a pin with `wake_en_i[i]=1`, `pull_up_o[i] = pull_en_i[i] & ~edge_rise_i[i]` and `pull_dn_o[i] = pull_en_i[i] & edge_rise_i[i]`. For a pin with `wake_en_i[i]=0`, `pull_up_o[i] = pull_en_i[i] & ~pull_dn_i[i]` and `pull_dn_o[i] = pull_en_i[i] & pull_dn_i[i]`. `pull_up_o[i]` and `pull_dn_o[i]` are never both 1.
- R9: While reset is held, `wake_o` is 0. For the first three clock cycles after reset is released, no edge is detected. This holds even if a pin level differs from its reset value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 4 | Asynchronous pin levels |
| idle_i | input | 1 | High while the core is in idle mode |
| wake_en_i | input | 4 | Per-pin wakeup enable |
| edge_rise_i | input | 4 | Per-pin release edge: 1 rising, 0 falling |
| pull_en_i | input | 4 | Per-pin pull resistor enable |
| pull_dn_i | input | 4 | Pull direction for pins with wakeup disabled: 1 down, 0 up |
| port_o | output | 4 | Synchronized port value for the core |
| wake_o | output | 1 | Single-cycle wakeup pulse to the sleep controller |
| pull_up_o | output | 4 | Pull-up select per pad |
| pull_dn_o | output | 4 | Pull-down select per pad |

## Verification
Suppose the detector's stored previous value drifts from the synchronized value. That fault shows up as a spurious or missing `wake_o` pulse exactly three cycles after a pin change. A missed re-seed after a configuration change shows up as a pulse in the cycle right after the change. A stuck pulse register shows up as `wake_o` high in two consecutive cycles, one cycle after the first pulse. Synchronizer faults appear on `port_o` two cycles after the pin moves. The bench compares every output against a cycle model on each cycle, so any of these faults is reported within one cycle of reaching a port.

// File: rtl/wkp_pkg.sv
// Package: shared widths and the per-pin edge configuration type for the
// wakeup input port. Assumes pins are grouped into one packed vector.
package wkp_pkg;

    localparam int unsigned PORT_W_DEF  = 4;
    localparam int unsigned SYNC_N_DEF  = 2;

    // Per-pin edge selection, packed so a whole port can be compared at once.
    typedef struct packed {
        logic rise;   // 1: rising edge releases idle, 0: falling edge
        logic en;     // 1: pin may release idle
    } pin_cfg_t;

    // Returns 1 when a transition prev->cur matches the pin configuration.
    function automatic logic edge_match(input logic cur, input logic prev,
                                        input pin_cfg_t cfg);
        logic rose;
        logic fell;
        rose = cur & ~prev;
        fell = ~cur & prev;
        return cfg.en & (cfg.rise ? rose : fell);
    endfunction

endpackage

// File: rtl/wkp_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency is implied) and that
// the reset value 0 is acceptable on every stage.
module wkp_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                // Shift the sample one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/wkp_edge_cell.sv
// Module: edge detector for one pin. Holds the previous synchronized value
// and flags a transition matching the pin's configuration. Assumes the
// caller masks the flag while the configuration or warm-up is unsettled;
// the stored value always follows the synchronized input, which is what
// re-seeds the detector after a configuration write.
module wkp_edge_cell
    import wkp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cur_i,
    input  pin_cfg_t cfg_i,
    output logic     hit_o
);

    logic prev_q;

    // Track the synchronized value one cycle behind.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur_i;
    end

    // Combine stored and current value with the selected edge.
    always_comb begin
        hit_o = edge_match(cur_i, prev_q, cfg_i);
    end

    // R4: a disabled pin never flags an edge.
    p_no_hit_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |-> !hit_o);

    // R3: a rising-edge pin only flags when its level is now high.
    p_rise_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && cfg_i.rise) |-> cur_i);

endmodule

// File: rtl/wkp_cfg_guard.sv
// Module: arming logic. Counts cycles since reset until the synchronizer
// and detectors hold real pin samples, and registers the edge
// configuration to spot any write. Assumes the configuration vector is
// driven from registers in the same clock domain.
module wkp_cfg_guard #(
    parameter int unsigned CFG_W  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             warm_o,
    output logic             arm_o
);

    localparam int unsigned FILL_MAX = STAGES + 1;
    localparam int unsigned FILL_W   = $clog2(FILL_MAX + 1);

    logic [FILL_W-1:0] fill_q;
    logic [CFG_W-1:0]  cfg_q;

    // Saturating count of cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              fill_q <= '0;
        else if (fill_q != FILL_W'(FILL_MAX))    fill_q <= fill_q + 1'b1;
    end

    // Remember last cycle's configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_i;
    end

    assign warm_o = (fill_q == FILL_W'(FILL_MAX));
    assign arm_o  = warm_o && (cfg_i == cfg_q);

    // R9: warm-up completes in exactly STAGES+1 cycles and then stays.
    p_warm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warm_o |=> warm_o);

endmodule

// File: rtl/wkp_pull_map.sv
// Module: pad pull selection. Wakeup pins take the pull matching their
// release edge; plain pins take the direction requested by software.
// Assumes a pull output only requests a resistor; it drives no level.
module wkp_pull_map #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] wake_en_i,
    input  logic [WIDTH-1:0] edge_rise_i,
    input  logic [WIDTH-1:0] pull_en_i,
    input  logic [WIDTH-1:0] pull_dn_i,
    output logic [WIDTH-1:0] pull_up_o,
    output logic [WIDTH-1:0] pull_dn_o
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            logic want_dn;
            // Pick the pull direction from the edge or the software request.
            always_comb begin
                want_dn      = wake_en_i[i] ? edge_rise_i[i] : pull_dn_i[i];
                pull_up_o[i] = pull_en_i[i] & ~want_dn;
                pull_dn_o[i] = pull_en_i[i] &  want_dn;
            end
            // R8: both pulls together would short the pad.
            always_comb begin
                p_pull_excl_r8: assert (!(pull_up_o[i] && pull_dn_o[i]));
            end
        end
    endgenerate

endmodule

// File: rtl/wkp_port.sv
// Module: edge-selectable wakeup input port (top). Synchronizes the pins,
// detects per-pin configured edges, and sends a single-cycle wakeup pulse
// while idle. Assumes idle_i and all configuration inputs are synchronous
// to clk; only pin_i is asynchronous.
module wkp_port
    import wkp_pkg::*;
#(
    parameter int unsigned PORT_W      = PORT_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_N_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic              idle_i,
    input  logic [PORT_W-1:0] wake_en_i,
    input  logic [PORT_W-1:0] edge_rise_i,
    input  logic [PORT_W-1:0] pull_en_i,
    input  logic [PORT_W-1:0] pull_dn_i,
    output logic [PORT_W-1:0] port_o,
    output logic              wake_o,
    output logic [PORT_W-1:0] pull_up_o,
    output logic [PORT_W-1:0] pull_dn_o
);

    localparam int unsigned CFG_W = 2 * PORT_W;

    logic [PORT_W-1:0] sync_w;
    logic [PORT_W-1:0] hit_w;
    logic [CFG_W-1:0]  cfg_vec;
    logic              warm_w;
    logic              arm_w;
    logic              wake_q;

    assign cfg_vec = {edge_rise_i, wake_en_i};

    wkp_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_w)
    );

    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_cell
            pin_cfg_t cfg_w;
            assign cfg_w.en   = wake_en_i[i];
            assign cfg_w.rise = edge_rise_i[i];
            wkp_edge_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .cur_i (sync_w[i]),
                .cfg_i (cfg_w),
                .hit_o (hit_w[i])
            );
        end
    endgenerate

    wkp_cfg_guard #(.CFG_W(CFG_W), .STAGES(SYNC_STAGES)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_i  (cfg_vec),
        .warm_o (warm_w),
        .arm_o  (arm_w)
    );

    wkp_pull_map #(.WIDTH(PORT_W)) u_pull (
        .wake_en_i   (wake_en_i),
        .edge_rise_i (edge_rise_i),
        .pull_en_i   (pull_en_i),
        .pull_dn_i   (pull_dn_i),
        .pull_up_o   (pull_up_o),
        .pull_dn_o   (pull_dn_o)
    );

    // Raise one pulse for any armed edge while idle; never two in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= idle_i && arm_w && (|hit_w) && !wake_q;
    end

    assign port_o = sync_w;
    assign wake_o = wake_q;

    // R6: the pulse lasts one cycle.
    p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R5: a pulse implies idle was reported in the detection cycle.
    p_idle_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(idle_i));

    // R7: a configuration write mutes the next cycle's pulse.
    p_cfg_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_w && cfg_vec != $past(cfg_vec)) |=> !wake_o);

    // R9: no pulse may come out of the warm-up window.
    p_warm_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_w |=> !wake_o);

    // R1: the readable value is the pin delayed by the synchronizer depth.
    p_port_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        warm_w |-> port_o == $past(pin_i, SYNC_STAGES));

endmodule

// File: tb/sim_wkp_port.sv
// Bench for wkp_port: directed corner cases plus seeded random traffic,
// compared each cycle against a cycle model built from the requirements.
module sim_wkp_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pin_i, wake_en_i, edge_rise_i, pull_en_i, pull_dn_i;
    logic       idle_i;
    logic [3:0] port_o, pull_up_o, pull_dn_o;
    logic       wake_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done   = 1'b0;

    // Model state
    logic [3:0] m_s1, m_s2, m_prev;
    logic [7:0] m_cfgq;
    int         m_fill;
    logic       m_wake;

    always #4 clk = ~clk;

    wkp_port u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .idle_i(idle_i),
        .wake_en_i(wake_en_i), .edge_rise_i(edge_rise_i),
        .pull_en_i(pull_en_i), .pull_dn_i(pull_dn_i),
        .port_o(port_o), .wake_o(wake_o),
        .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o)
    );

    function automatic logic [3:0] exp_up(input logic [3:0] en, rise, pe, pd);
        logic [3:0] r;
        for (int i = 0; i < 4; i++)
            r[i] = pe[i] & ~(en[i] ? rise[i] : pd[i]);
        return r;
    endfunction

    function automatic logic [3:0] exp_dn(input logic [3:0] en, rise, pe, pd);
        logic [3:0] r;
        for (int i = 0; i < 4; i++)
            r[i] = pe[i] & (en[i] ? rise[i] : pd[i]);
        return r;
    endfunction

    function automatic logic any_edge(input logic [3:0] cur, prev, en, rise);
        logic h = 1'b0;
        for (int i = 0; i < 4; i++)
            if (en[i] && (rise[i] ? (cur[i] && !prev[i]) : (!cur[i] && prev[i])))
                h = 1'b1;
        return h;
    endfunction

    task automatic check(input string req, input logic [7:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // One clock: update the model from the inputs seen at the edge, then compare.
    task automatic step();
        logic nw;
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_cfgq = '0; m_fill = 0; m_wake = 1'b0;
        end else begin
            nw = idle_i && (m_fill == 3) && ({edge_rise_i, wake_en_i} == m_cfgq)
                 && !m_wake && any_edge(m_s2, m_prev, wake_en_i, edge_rise_i);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
            m_cfgq = {edge_rise_i, wake_en_i};
            if (m_fill < 3) m_fill++;
            m_wake = nw;
        end
        @(negedge clk);
        if (wake_o === 1'b1) pulses++;
        check("R1 port", {4'h0, port_o}, {4'h0, m_s2});
        check("R6 wake", {7'h0, wake_o}, {7'h0, m_wake});
        check("R8 pull", {pull_up_o, pull_dn_o},
              {exp_up(wake_en_i, edge_rise_i, pull_en_i, pull_dn_i),
               exp_dn(wake_en_i, edge_rise_i, pull_en_i, pull_dn_i)});
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic expect_pulses(input string req, input int n, input int exp);
        pulses = 0;
        steps(n);
        check(req, 8'(pulses), 8'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pin_i = 4'hF; idle_i = 1'b1;
        wake_en_i = 4'hF; edge_rise_i = 4'hF; pull_en_i = 4'h0; pull_dn_i = 4'h0;
        @(negedge clk);
        steps(3);
        check("R1 reset port", {4'h0, port_o}, 8'h00);
        check("R9 reset wake", {7'h0, wake_o}, 8'h00);
        // R9: pins high with rising wake enabled must not fire on warm-up.
        rst_n = 1'b1;
        expect_pulses("R9 warmup", 6, 0);
        check("R1 settled", {4'h0, port_o}, 8'h0F);

        // R2: falling edge on pin 0.
        wake_en_i = 4'h1; edge_rise_i = 4'h0; pin_i = 4'h1;
        steps(5);
        pin_i = 4'h0;
        step(); step();
        check("R2 before", {7'h0, wake_o}, 8'h00);
        step();
        check("R2 third", {7'h0, wake_o}, 8'h01);
        expect_pulses("R2 single", 4, 0);
        // R3: rising-edge pin ignores a fall, fires on a rise.
        edge_rise_i = 4'h1; steps(4);
        pin_i = 4'h1; expect_pulses("R3 rise", 6, 1);
        pin_i = 4'h0; expect_pulses("R3 fall ignored", 6, 0);
        // R4: disabled pins toggle, no wake, still readable.
        wake_en_i = 4'h0; steps(3);
        pin_i = 4'hA; expect_pulses("R4 disabled", 6, 0);
        check("R4 readable", {4'h0, port_o}, 8'h0A);
        pin_i = 4'h0; expect_pulses("R4 disabled back", 6, 0);
        // R5: edge while not idle is dropped for good.
        wake_en_i = 4'hF; edge_rise_i = 4'hF; steps(3);
        idle_i = 1'b0; pin_i = 4'h4;
        steps(4);
        idle_i = 1'b1;
        expect_pulses("R5 not idle", 5, 0);
        // R6: simultaneous edges on several pins give one pulse.
        pin_i = 4'hF; expect_pulses("R6 multi", 6, 1);
        // R6: edges on successive cycles never give back-to-back pulses.
        edge_rise_i = 4'h0; steps(3);
        pin_i = 4'hE; step(); pin_i = 4'hC;
        expect_pulses("R6 consecutive", 6, 1);
        // R7: configuration write in the detection cycle hides the edge.
        wake_en_i = 4'h7; edge_rise_i = 4'h0; pin_i = 4'hF; steps(5);
        pin_i = 4'hE; step(); step();
        wake_en_i = 4'hF;
        expect_pulses("R7 write mutes", 6, 0);
        // R7: flipping edge polarity with pins stable makes no pulse.
        edge_rise_i = 4'hF; expect_pulses("R7 polarity flip", 4, 0);
        edge_rise_i = 4'h0; expect_pulses("R7 polarity back", 4, 0);
        // R8: pull mapping for each pin kind.
        wake_en_i = 4'h3; edge_rise_i = 4'h2; pull_en_i = 4'hF; pull_dn_i = 4'h8;
        step();
        check("R8 map", {pull_up_o, pull_dn_o}, 8'h5A);

        // Seeded random traffic.
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(0, 3) == 0) pin_i = pin_i ^ 4'($urandom_range(1, 15));
            if ($urandom_range(0, 9) == 0) idle_i = ~idle_i;
            if ($urandom_range(0, 29) == 0) begin
                wake_en_i = 4'($urandom); edge_rise_i = 4'($urandom);
                pull_en_i = 4'($urandom); pull_dn_i = 4'($urandom);
            end
            if ($urandom_range(0, 499) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
            step();
        end
        finish_run();
    end

endmodule